// File: doc/BRIEF.md
# Tri-State PWM Gate-Drive Sequencer

This block turns a three-level PWM command into the two gate enables of a synchronous buck power stage. External comparators have already sorted the PWM pin into high, low or mid (tri-state). The sequencer enforces a both-off dead time between the two switches. It turns both switches off when the command stays at mid for a hold-off time. When diode emulation is on, it keeps the low-side switch conducting after a high-to-mid step until the zero-crossing comparator reports that the inductor current has fallen to zero.

All timing is counted in clock cycles: dead time `DEAD_CYC`, hold-off `HOLD_CYC` and zero-crossing blanking `BLANK_CYC`. While the active-low enable is low, both gates are held off. After it is released, the block waits for a definite high or low command before it drives either gate.

Top module: `tpwm_gate_ctrl`

## Requirements
- R1: While `rst` is high or `dis_n` is low, both gates are off one clock after sampling. After release, both stay off while the command is mid.
- R2: When high is sampled while the low-side gate is on, the low gate goes off and both stay off for exactly `DEAD_CYC` cycles, then the high gate turns on. From the both-off idle state, the high gate turns on one cycle after high is sampled.
- R3: Low mirrors R2, with the roles of the two gates swapped.
- R4: `hs_gate` and `ls_gate` are never high in the same cycle.
- R5: When mid follows low, the low gate stays on for `HOLD_CYC` cycles and then both gates go off.
- R6: When mid follows high with `de_en` low, the high gate stays on for `HOLD_CYC` cycles and then both go off. The low gate never turns on, whatever `zcd` does.
- R7: When mid follows high with `de_en` high, both gates are off for `DEAD_CYC` cycles and then the low gate turns on.
- R8: For the first `BLANK_CYC` cycles of that low-side interval, `zcd` is ignored.
- R9: After blanking, `zcd` high turns the low gate off on the next cycle. Both then stay off while the command remains mid.
- R10: A return to high or low aborts a running hold-off or emulation interval. Returning to the level already being driven keeps that gate on. The opposite level goes through dead time.
- R11: `pwm_lvl` is encoded as 2'b00 low, 2'b01 high, and 2'b10 or 2'b11 mid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dis_n | input | 1 | Enable, active low disables both gates |
| pwm_lvl | input | 2 | Decoded PWM level (00 low, 01 high, 1x mid) |
| de_en | input | 1 | Diode-emulation enable |
| zcd | input | 1 | Zero-crossing comparator, high at zero inductor current |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The assertions assume that `pwm_lvl`, `de_en` and `zcd` are synchronous to `clk`, with the comparators' hysteresis and synchronisation handled upstream, and that they hold one value across each edge. The bench changes every input only on the falling edge. It uses mid codes 2'b10 and 2'b11 interchangeably. It places `zcd` pulses both inside and after the blanking window, so that the zero-crossing and dead-time properties see both outcomes.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_MID  = 2'b10
    } lvl_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEAD,
        PH_HS,
        PH_LS,
        PH_HOLD_HS,
        PH_HOLD_LS,
        PH_DIODE
    } phase_e;

    typedef enum logic [1:0] {
        GOAL_HS,
        GOAL_LS,
        GOAL_DIODE
    } goal_e;

    typedef struct packed {
        phase_e phase;
        goal_e  goal;
    } seq_t;

    function automatic lvl_e decode_lvl(input logic [1:0] code);
        if (code[1])
            return LVL_MID;
        else if (code[0])
            return LVL_HIGH;
        else
            return LVL_LOW;
    endfunction

    function automatic logic phase_drives_hs(input phase_e p);
        return (p == PH_HS) || (p == PH_HOLD_HS);
    endfunction

    function automatic logic phase_drives_ls(input phase_e p);
        return (p == PH_LS) || (p == PH_HOLD_LS) || (p == PH_DIODE);
    endfunction

endpackage

// File: rtl/tpwm_lvl_dec.sv
module tpwm_lvl_dec
    import tpwm_pkg::*;
(
    input  logic [1:0] code,
    output lvl_e       lvl
);
    assign lvl = decode_lvl(code);
endmodule

// File: rtl/tpwm_cycle_timer.sv
module tpwm_cycle_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/tpwm_phase_fsm.sv
module tpwm_phase_fsm
    import tpwm_pkg::*;
#(
    parameter int DEAD_CYC  = 3,
    parameter int HOLD_CYC  = 8,
    parameter int BLANK_CYC = 4,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dis_n,
    input  lvl_e          lvl,
    input  logic          de_en,
    input  logic          zcd,
    input  logic [CW-1:0] count,
    output logic          t_clr,
    output logic          t_inc,
    output phase_e        phase
);
    localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CYC);

    seq_t cur, nxt;

    always_comb begin
        nxt   = cur;
        t_clr = 1'b0;
        t_inc = 1'b0;
        unique case (cur.phase)
            PH_IDLE: begin
                if (lvl == LVL_HIGH)     nxt.phase = PH_HS;
                else if (lvl == LVL_LOW) nxt.phase = PH_LS;
            end
            PH_HS: begin
                if (lvl == LVL_LOW) begin
                    nxt   = '{phase: PH_DEAD, goal: GOAL_LS};
                    t_clr = 1'b1;
                end else if (lvl == LVL_MID) begin
                    t_clr = 1'b1;
                    if (de_en) nxt = '{phase: PH_DEAD, goal: GOAL_DIODE};
                    else       nxt.phase = PH_HOLD_HS;
                end
            end
            PH_LS: begin
                if (lvl == LVL_HIGH) begin
                    nxt   = '{phase: PH_DEAD, goal: GOAL_HS};
                    t_clr = 1'b1;
                end else if (lvl == LVL_MID) begin
                    nxt.phase = PH_HOLD_LS;
                    t_clr     = 1'b1;
                end
            end
            PH_HOLD_HS, PH_HOLD_LS: begin
                if (lvl == LVL_HIGH) begin
                    if (cur.phase == PH_HOLD_HS) nxt.phase = PH_HS;
                    else begin
                        nxt   = '{phase: PH_DEAD, goal: GOAL_HS};
                        t_clr = 1'b1;
                    end
                end else if (lvl == LVL_LOW) begin
                    if (cur.phase == PH_HOLD_LS) nxt.phase = PH_LS;
                    else begin
                        nxt   = '{phase: PH_DEAD, goal: GOAL_LS};
                        t_clr = 1'b1;
                    end
                end else if (count == HOLD_LAST) begin
                    nxt.phase = PH_IDLE;
                end else begin
                    t_inc = 1'b1;
                end
            end
            PH_DEAD: begin
                if (count == DEAD_LAST) begin
                    t_clr = 1'b1;
                    if (lvl == LVL_HIGH)         nxt.phase = PH_HS;
                    else if (lvl == LVL_LOW)     nxt.phase = PH_LS;
                    else if (cur.goal == GOAL_DIODE) nxt.phase = PH_DIODE;
                    else                         nxt.phase = PH_IDLE;
                end else begin
                    t_inc = 1'b1;
                end
            end
            PH_DIODE: begin
                if (lvl == LVL_HIGH) begin
                    nxt   = '{phase: PH_DEAD, goal: GOAL_HS};
                    t_clr = 1'b1;
                end else if (lvl == LVL_LOW) begin
                    nxt.phase = PH_LS;
                end else if (count != BLANK_END) begin
                    t_inc = 1'b1;
                end else if (zcd) begin
                    nxt.phase = PH_IDLE;
                end
            end
            default: nxt = '{phase: PH_IDLE, goal: GOAL_HS};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !dis_n)
            cur <= '{phase: PH_IDLE, goal: GOAL_HS};
        else
            cur <= nxt;
    end

    assign phase = cur.phase;
endmodule

// File: rtl/tpwm_gate_map.sv
module tpwm_gate_map
    import tpwm_pkg::*;
(
    input  phase_e phase,
    output logic   hs_gate,
    output logic   ls_gate
);
    assign hs_gate = phase_drives_hs(phase);
    assign ls_gate = phase_drives_ls(phase);
endmodule

// File: rtl/tpwm_gate_ctrl.sv
module tpwm_gate_ctrl
    import tpwm_pkg::*;
#(
    parameter int DEAD_CYC  = 3,
    parameter int HOLD_CYC  = 8,
    parameter int BLANK_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dis_n,
    input  logic [1:0] pwm_lvl,
    input  logic       de_en,
    input  logic       zcd,
    output logic       hs_gate,
    output logic       ls_gate
);
    localparam int MAXA = (DEAD_CYC > HOLD_CYC) ? DEAD_CYC : HOLD_CYC;
    localparam int MAXV = (MAXA > BLANK_CYC + 1) ? MAXA : BLANK_CYC + 1;
    localparam int CW   = $clog2(MAXV + 1);

    lvl_e          lvl;
    phase_e        phase;
    logic          t_clr, t_inc;
    logic [CW-1:0] count;

    tpwm_lvl_dec u_dec (
        .code (pwm_lvl),
        .lvl  (lvl)
    );

    tpwm_cycle_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (t_clr),
        .inc   (t_inc),
        .count (count)
    );

    tpwm_phase_fsm #(
        .DEAD_CYC  (DEAD_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .BLANK_CYC (BLANK_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .dis_n (dis_n),
        .lvl   (lvl),
        .de_en (de_en),
        .zcd   (zcd),
        .count (count),
        .t_clr (t_clr),
        .t_inc (t_inc),
        .phase (phase)
    );

    tpwm_gate_map u_map (
        .phase   (phase),
        .hs_gate (hs_gate),
        .ls_gate (ls_gate)
    );
endmodule

// File: rtl/tpwm_gate_ctrl_chk.sv
module tpwm_gate_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       dis_n,
    input logic [1:0] pwm_lvl,
    input logic       hs_gate,
    input logic       ls_gate
);
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(hs_gate && ls_gate)); // R4

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (rst)
        !dis_n |=> (!hs_gate && !ls_gate)); // R1

    AST_HS_RISE_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_gate) |-> $past(!ls_gate)); // R2

    AST_LS_RISE_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_gate) |-> $past(!hs_gate)); // R3

    AST_HIGH_DROPS_LS: assert property (@(posedge clk) disable iff (rst)
        (pwm_lvl == 2'b01) |=> !ls_gate); // R2

    AST_LOW_DROPS_HS: assert property (@(posedge clk) disable iff (rst)
        (pwm_lvl == 2'b00) |=> !hs_gate); // R3
endmodule

bind tpwm_gate_ctrl tpwm_gate_ctrl_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .dis_n   (dis_n),
    .pwm_lvl (pwm_lvl),
    .hs_gate (hs_gate),
    .ls_gate (ls_gate)
);

// File: tb/tpwm_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module tpwm_gate_ctrl_tb_top;
    localparam int DEAD  = 3;
    localparam int HOLD  = 8;
    localparam int BLANK = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dis_n = 1'b0;
    logic [1:0] pwm_lvl = 2'b10;
    logic       de_en = 1'b0;
    logic       zcd = 1'b0;
    logic       hs_gate, ls_gate;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    tpwm_gate_ctrl #(.DEAD_CYC(DEAD), .HOLD_CYC(HOLD), .BLANK_CYC(BLANK)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .dis_n   (dis_n),
        .pwm_lvl (pwm_lvl),
        .de_en   (de_en),
        .zcd     (zcd),
        .hs_gate (hs_gate),
        .ls_gate (ls_gate)
    );

    // Behavioural reference: mode codes with down-counting timers.
    // 0 off, 1 high on, 2 low on, 3 gap, 4 high held, 5 low held, 6 emulating
    int mode = 0;
    int left = 0;
    int after_gap = 0;   // 0 off, 6 emulate
    bit exp_h, exp_l;

    always @(posedge clk) begin
        int lv;
        lv = pwm_lvl[1] ? 2 : (pwm_lvl[0] ? 1 : 0);   // 0 low, 1 high, 2 mid
        if (rst || !dis_n) begin
            mode = 0;
        end else begin
            case (mode)
                0: if (lv == 1) mode = 1; else if (lv == 0) mode = 2;
                1: if (lv == 0) begin mode = 3; left = DEAD; after_gap = 0; end
                   else if (lv == 2) begin
                       if (de_en) begin mode = 3; left = DEAD; after_gap = 6; end
                       else begin mode = 4; left = HOLD; end
                   end
                2: if (lv == 1) begin mode = 3; left = DEAD; after_gap = 0; end
                   else if (lv == 2) begin mode = 5; left = HOLD; end
                4, 5: begin
                    if (lv == 1) begin
                        if (mode == 4) mode = 1;
                        else begin mode = 3; left = DEAD; after_gap = 0; end
                    end else if (lv == 0) begin
                        if (mode == 5) mode = 2;
                        else begin mode = 3; left = DEAD; after_gap = 0; end
                    end else begin
                        left = left - 1;
                        if (left == 0) mode = 0;
                    end
                end
                3: begin
                    left = left - 1;
                    if (left == 0) begin
                        if (lv == 1) mode = 1;
                        else if (lv == 0) mode = 2;
                        else if (after_gap == 6) begin mode = 6; left = BLANK; end
                        else mode = 0;
                    end
                end
                6: begin
                    if (lv == 1) begin mode = 3; left = DEAD; after_gap = 0; end
                    else if (lv == 0) mode = 2;
                    else if (left > 0) left = left - 1;
                    else if (zcd) mode = 0;
                end
                default: mode = 0;
            endcase
        end
        exp_h = (mode == 1) || (mode == 4);
        exp_l = (mode == 2) || (mode == 5) || (mode == 6);
    end

    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (hs_gate !== exp_h || ls_gate !== exp_l) begin
                n_fail++;
                $display("FAIL %s model compare: gates hs=%b ls=%b expected hs=%b ls=%b at %0t",
                         cur_req, hs_gate, ls_gate, exp_h, exp_l, $time);
            end
            n_chk++;
            if (hs_gate === 1'b1 && ls_gate === 1'b1) begin
                n_fail++;
                $display("FAIL R4 overlap: hs=%b ls=%b expected not both 1", hs_gate, ls_gate);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_gates(input bit h, input bit l, input string tag);
        n_chk++;
        if (hs_gate !== h || ls_gate !== l) begin
            n_fail++;
            $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", tag, hs_gate, ls_gate, h, l);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        step(4);
        expect_gates(0, 0, "R1 reset");
        rst = 1'b0;
        step(3);
        expect_gates(0, 0, "R1 disabled");
        dis_n = 1'b1;
        step(4);
        expect_gates(0, 0, "R1 waits on mid after release");

        cur_req = "R2";
        pwm_lvl = 2'b01; step(1);
        expect_gates(1, 0, "R2 idle to high");

        cur_req = "R3";
        pwm_lvl = 2'b00; step(1);
        expect_gates(0, 0, "R3 dead time start");
        step(DEAD - 1);
        expect_gates(0, 0, "R3 dead time end");
        step(1);
        expect_gates(0, 1, "R3 low side on");

        cur_req = "R2";
        pwm_lvl = 2'b01; step(DEAD);
        expect_gates(0, 0, "R2 dead time");
        step(1);
        expect_gates(1, 0, "R2 high side on");

        cur_req = "R5";
        pwm_lvl = 2'b00; step(DEAD + 3);
        pwm_lvl = 2'b10; step(HOLD);
        expect_gates(0, 1, "R5 low held through hold-off");
        step(1);
        expect_gates(0, 0, "R5 both off after hold-off");
        step(3);

        cur_req = "R10";
        pwm_lvl = 2'b00; step(2);
        pwm_lvl = 2'b11; step(4);
        pwm_lvl = 2'b00; step(HOLD);
        expect_gates(0, 1, "R10 hold-off aborted by low");

        cur_req = "R6";
        pwm_lvl = 2'b01; step(DEAD + 3);
        de_en = 1'b0;
        pwm_lvl = 2'b10;
        for (int i = 0; i < HOLD + 6; i++) begin
            zcd = i[0];
            step(1);
            if (i < HOLD) expect_gates(1, 0, "R6 high held");
            else          expect_gates(0, 0, "R6 both off, zcd ignored");
        end
        zcd = 1'b0;

        cur_req = "R7";
        pwm_lvl = 2'b01; step(2);
        de_en = 1'b1;
        pwm_lvl = 2'b10; step(DEAD);
        expect_gates(0, 0, "R7 dead time before emulation");
        step(1);
        expect_gates(0, 1, "R7 low side on");

        cur_req = "R8";
        zcd = 1'b1; step(1);
        zcd = 1'b0;
        expect_gates(0, 1, "R8 zcd inside blanking ignored");
        zcd = 1'b1; step(BLANK - 1);
        expect_gates(0, 1, "R8 zcd held through blanking");

        cur_req = "R9";
        step(1);
        expect_gates(0, 0, "R9 zcd after blanking ends low side");
        zcd = 1'b0; step(4);
        expect_gates(0, 0, "R9 stays off in mid");

        cur_req = "R10";
        pwm_lvl = 2'b01; step(3);
        pwm_lvl = 2'b10; step(DEAD + 2);
        pwm_lvl = 2'b01; step(1);
        expect_gates(0, 0, "R10 emulation aborted by high");
        step(DEAD);
        expect_gates(1, 0, "R10 high after abort");

        cur_req = "R11";
        de_en = 1'b0;
        pwm_lvl = 2'b11; step(HOLD + 1);
        expect_gates(0, 0, "R11 code 11 acts as mid");

        cur_req = "R1";
        pwm_lvl = 2'b00; step(5);
        dis_n = 1'b0; step(1);
        expect_gates(0, 0, "R1 disable while driving");
        step(2);
        dis_n = 1'b1;
        pwm_lvl = 2'b10; step(3);
        expect_gates(0, 0, "R1 released into mid");
        pwm_lvl = 2'b00; step(1);
        expect_gates(0, 1, "R1 resumes on low");
        step(3);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            finish_run();
        end
    end
endmodule